// File: doc/BRIEF.md
# Multi-PID Translation Entry Checker

This block decides whether a memory request is translated by an entry in a set-associative translation cache. A request gives the effective address, the access kind, three process identifiers, the machine address-space and privilege bits, a 32/64-bit addressing mode, and an optional alternate-context process identifier with its own address-space and privilege bits. The cache itself sits outside the block. On start, the block walks every slot in order, set by set and way by way within a set. Each cycle it drives a slot index out, and the surrounding array returns that slot's fields combinationally in the same cycle.

Each entry has a valid flag, a page-size code, a translation ID, an address-space bit, a virtual page base, a physical page base and six permission bits. The walk ends at the first entry that does not miss, or after the final slot. The block then pulses `done` with a result code, the physical address, the granted permissions and the index of the deciding slot. Raising the exception is left to the caller.

Top module: `tlb_entry_checker`

## Requirements
- R1: `start` is taken only while `busy` is low. It latches every request input. From the next cycle on, `cand_set`/`cand_way` step through all slots, one per cycle: ways ascend within a set, and sets ascend. The entry fields are sampled in the cycle the slot is presented. When the slot at walk position k (counting from 0) decides the result, `busy` drops and `done` is high for one cycle, k+1 clock edges after the edge that accepted `start`. A `start` raised while `busy` is high has no effect on the walk or its result.
- R2: The page size is 1024 bytes shifted left by `ent_size`. An entry hits on address only if the effective address and `ent_vpage` are equal in all bits above the page offset.
- R3: On a hit, `res_paddr` takes its page bits from `ent_ppage` and its offset bits from the effective address.
- R4: With `req_wide` low, bits 63..32 of the address are taken as zero before comparison and translation. With `req_wide` high, all 64 bits are compared.
- R5: A translation ID of zero matches any process. Otherwise the entry matches if the ID equals `pid_a`, or equals `pid_b` while `pid_b` is nonzero, or equals `pid_c` while `pid_c` is nonzero.
- R6: For a load (`req_kind`=0) or store (`req_kind`=1) with `alt_en` high, only `alt_pid` is compared against the translation ID. The effective address space comes from `alt_space` and the privilege from `alt_user`, not from the machine bits.
- R7: For an instruction fetch (`req_kind`=2), the effective address space is `cpu_ispace` and the privilege is `cpu_user`, and `alt_en` has no effect. For loads and stores without `alt_en`, the address space is `cpu_dspace`.
- R8: An entry whose `ent_space` differs from the effective address space counts as a miss, and the walk continues to the next slot.
- R9: `ent_perm` bits are [0] user read, [1] user write, [2] user execute, [3] supervisor read, [4] supervisor write, [5] supervisor execute. A user access (effective privilege 1) uses bits [2:0], and a supervisor access uses bits [5:3]. The chosen triple is reported on `res_perm` as {execute, write, read}. A load needs read, a store needs write, and a fetch needs execute. Result codes are: 0 miss, 1 hit, 2 data violation (a denied load or store), 3 execute violation (a denied fetch).
- R10: The first entry that matches on validity, address, process ID and address space ends the walk, whether it grants or denies, and later slots are ignored. If no slot matches, the result is 0 (miss) and `res_paddr`, `res_perm`, `res_set` and `res_way` are zero.
- R11: An entry with `ent_valid` low never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk with the request inputs |
| req_addr | input | ADDR_W | Effective address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_wide | input | 1 | 1 = 64-bit addressing, 0 = 32-bit |
| cpu_ispace | input | 1 | Machine instruction address space |
| cpu_dspace | input | 1 | Machine data address space |
| cpu_user | input | 1 | Machine privilege, 1 = user |
| pid_a | input | PID_W | First process ID |
| pid_b | input | PID_W | Second process ID |
| pid_c | input | PID_W | Third process ID |
| alt_en | input | 1 | Use alternate context for load/store |
| alt_pid | input | PID_W | Alternate-context process ID |
| alt_space | input | 1 | Alternate-context address space |
| alt_user | input | 1 | Alternate-context privilege |
| cand_set | output | SET_W | Set of the slot presented this cycle |
| cand_way | output | WAY_W | Way of the slot presented this cycle |
| ent_valid | input | 1 | Entry valid |
| ent_size | input | SIZE_W | Page-size code |
| ent_tid | input | PID_W | Translation ID |
| ent_space | input | 1 | Entry address space |
| ent_vpage | input | ADDR_W | Virtual page base |
| ent_ppage | input | PA_W | Physical page base |
| ent_perm | input | 6 | Permission bits |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| res_code | output | 2 | Result code |
| res_paddr | output | PA_W | Physical address |
| res_perm | output | 3 | Granted permissions {x,w,r} |
| res_set | output | SET_W | Set of deciding slot |
| res_way | output | WAY_W | Way of deciding slot |

## Verification
A wrong step in the slot counter shows up as a `done` that comes a cycle early or late, or as a wrong `res_set`/`res_way`. The bench checks both on every walk, so such an error is visible on the first walk that decides anywhere other than the final slot. A wrong privilege or address-space selection flips the result code or `res_perm` on the same walk. A bad page mask shows up as a miss where a hit is expected, or as the wrong offset bits in `res_paddr`. A stale latched request would change the result of the walk that follows a `start` pulse raised during a busy walk.

// File: rtl/tlbck_pkg.sv
// Shared types for the translation entry checker.
// Assumes: access and result encodings are fixed and visible at the top ports.
package tlbck_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        RES_MISS  = 2'd0,
        RES_HIT   = 2'd1,
        RES_DVIOL = 2'd2,
        RES_XVIOL = 2'd3
    } res_e;

    localparam int MIN_PAGE_SHIFT = 10;
    localparam int NPID           = 3;

endpackage

// File: rtl/tlbck_ctx.sv
// Picks the effective address space, privilege and process-ID source.
// Assumes: fetches never use the alternate context; the reserved kind acts as a load.
module tlbck_ctx
    import tlbck_pkg::*;
(
    input  acc_e kind,
    input  logic cpu_ispace,
    input  logic cpu_dspace,
    input  logic cpu_user,
    input  logic alt_en,
    input  logic alt_space,
    input  logic alt_user,
    output logic use_alt,
    output logic eff_space,
    output logic eff_user
);

    // Context selection: fetch > alternate context > machine data state.
    always_comb begin
        use_alt = alt_en && (kind != ACC_FETCH);
        if (kind == ACC_FETCH) begin
            eff_space = cpu_ispace;
            eff_user  = cpu_user;
        end else if (use_alt) begin
            eff_space = alt_space;
            eff_user  = alt_user;
        end else begin
            eff_space = cpu_dspace;
            eff_user  = cpu_user;
        end
    end

endmodule

// File: rtl/tlbck_addr.sv
// Address compare and physical address formation for one entry.
// Assumes: PA_W <= ADDR_W; a size code that overflows the width gives a mask of zero.
module tlbck_addr
    import tlbck_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int PA_W   = 48,
    parameter int SIZE_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] vpage,
    input  logic [PA_W-1:0]   ppage,
    output logic              addr_hit,
    output logic [PA_W-1:0]   paddr
);

    localparam logic [ADDR_W-1:0] BASE_PAGE = ADDR_W'(1) << MIN_PAGE_SHIFT;

    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] page_mask;
    logic [PA_W-1:0]   pa_mask;

    // Narrow-mode truncation only exists when the address is wider than 32 bits.
    generate
        if (ADDR_W > 32) begin : g_wide
            assign eff_addr = wide ? addr : {{(ADDR_W-32){1'b0}}, addr[31:0]};
        end else begin : g_narrow
            assign eff_addr = addr;
        end
    endgenerate

    // Page mask from the size code, then compare and splice.
    always_comb begin
        page_mask = ~((BASE_PAGE << size) - ADDR_W'(1));
        pa_mask   = page_mask[PA_W-1:0];
        addr_hit  = ((eff_addr ^ vpage) & page_mask) == '0;
        paddr     = (ppage & pa_mask) | (eff_addr[PA_W-1:0] & ~pa_mask);
    end

endmodule

// File: rtl/tlbck_eval.sv
// Full evaluation of one candidate entry: validity, address, process ID,
// address space and permission, reduced to a result code.
// Assumes: inputs are stable for the cycle in which the entry is presented.
module tlbck_eval
    import tlbck_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int PA_W   = 48,
    parameter int PID_W  = 14,
    parameter int SIZE_W = 4
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wide,
    input  acc_e                        kind,
    input  logic                        use_alt,
    input  logic                        eff_space,
    input  logic                        eff_user,
    input  logic [NPID-1:0][PID_W-1:0]  pids,
    input  logic [PID_W-1:0]            alt_pid,
    input  logic                        ent_valid,
    input  logic [SIZE_W-1:0]           ent_size,
    input  logic [PID_W-1:0]            ent_tid,
    input  logic                        ent_space,
    input  logic [ADDR_W-1:0]           ent_vpage,
    input  logic [PA_W-1:0]             ent_ppage,
    input  logic [5:0]                  ent_perm,
    output res_e                        code,
    output logic [PA_W-1:0]             paddr,
    output logic [2:0]                  perm
);

    logic            addr_hit;
    logic [NPID-1:0] pid_eq;
    logic            pid_hit;
    logic            match;
    logic            allowed;

    tlbck_addr #(.ADDR_W(ADDR_W), .PA_W(PA_W), .SIZE_W(SIZE_W)) i_addr (
        .addr     (addr),
        .wide     (wide),
        .size     (ent_size),
        .vpage    (ent_vpage),
        .ppage    (ent_ppage),
        .addr_hit (addr_hit),
        .paddr    (paddr)
    );

    // One comparator per process-ID register; all but the first need a nonzero ID.
    generate
        for (genvar g = 0; g < NPID; g++) begin : g_pid
            if (g == 0) begin : g_first
                assign pid_eq[g] = (ent_tid == pids[g]);
            end else begin : g_rest
                assign pid_eq[g] = (pids[g] != '0) && (ent_tid == pids[g]);
            end
        end
    endgenerate

    // Process-ID selection between the alternate context and the register set.
    always_comb begin
        if (ent_tid == '0)
            pid_hit = 1'b1;
        else if (use_alt)
            pid_hit = (ent_tid == alt_pid);
        else
            pid_hit = |pid_eq;
    end

    // Permission triple for the effective privilege and its check against the access.
    always_comb begin
        perm  = eff_user ? ent_perm[2:0] : ent_perm[5:3];
        match = ent_valid && addr_hit && pid_hit && (ent_space == eff_space);
        case (kind)
            ACC_STORE: allowed = perm[1];
            ACC_FETCH: allowed = perm[2];
            default:   allowed = perm[0];
        endcase
        if (!match)
            code = RES_MISS;
        else if (allowed)
            code = RES_HIT;
        else if (kind == ACC_FETCH)
            code = RES_XVIOL;
        else
            code = RES_DVIOL;
    end

endmodule

// File: rtl/tlbck_seq.sv
// Slot walker: presents one slot per cycle, set-major and way-minor, and
// stops at the first deciding entry or after the last slot.
// Assumes: decided is valid combinationally for the slot being presented.
module tlbck_seq #(
    parameter int NSETS = 2,
    parameter int WAYS  = 4,
    parameter int SET_W = 1,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             decided,
    output logic             busy,
    output logic [SET_W-1:0] set_q,
    output logic [WAY_W-1:0] way_q,
    output logic             finish
);

    localparam logic [SET_W-1:0] SET_LAST = SET_W'(NSETS - 1);
    localparam logic [WAY_W-1:0] WAY_LAST = WAY_W'(WAYS - 1);

    logic last_slot;

    // End-of-walk detection.
    always_comb begin
        last_slot = (set_q == SET_LAST) && (way_q == WAY_LAST);
        finish    = busy && (decided || last_slot);
    end

    // Walk state: idle, start, advance way, wrap into the next set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            set_q <= '0;
            way_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                set_q <= '0;
                way_q <= '0;
            end
        end else if (finish) begin
            busy <= 1'b0;
        end else if (way_q == WAY_LAST) begin
            way_q <= '0;
            set_q <= set_q + 1'b1;
        end else begin
            way_q <= way_q + 1'b1;
        end
    end

    // R1: inside a set the walk moves to the next way.
    p_way_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish && way_q != WAY_LAST) |=>
        (busy && way_q == $past(way_q) + 1'b1 && set_q == $past(set_q)));

    // R1: after the last way the walk moves to way 0 of the next set.
    p_set_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish && way_q == WAY_LAST) |=>
        (busy && way_q == '0 && set_q == $past(set_q) + 1'b1));

    // R1: an idle walker without start stays idle.
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

endmodule

// File: rtl/tlb_entry_checker.sv
// Top: latches a translation request, walks candidate slots through the
// sequencer and registers the result of the first deciding entry.
// Assumes: the external array returns a slot's fields in the cycle its index is driven.
module tlb_entry_checker
    import tlbck_pkg::*;
#(
    parameter int  ADDR_W = 64,
    parameter int  PA_W   = 48,
    parameter int  PID_W  = 14,
    parameter int  SIZE_W = 4,
    parameter int  NSETS  = 2,
    parameter int  WAYS   = 4,
    localparam int SET_W  = (NSETS > 1) ? $clog2(NSETS) : 1,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic              req_wide,
    input  logic              cpu_ispace,
    input  logic              cpu_dspace,
    input  logic              cpu_user,
    input  logic [PID_W-1:0]  pid_a,
    input  logic [PID_W-1:0]  pid_b,
    input  logic [PID_W-1:0]  pid_c,
    input  logic              alt_en,
    input  logic [PID_W-1:0]  alt_pid,
    input  logic              alt_space,
    input  logic              alt_user,
    output logic [SET_W-1:0]  cand_set,
    output logic [WAY_W-1:0]  cand_way,
    input  logic              ent_valid,
    input  logic [SIZE_W-1:0] ent_size,
    input  logic [PID_W-1:0]  ent_tid,
    input  logic              ent_space,
    input  logic [ADDR_W-1:0] ent_vpage,
    input  logic [PA_W-1:0]   ent_ppage,
    input  logic [5:0]        ent_perm,
    output logic              busy,
    output logic              done,
    output logic [1:0]        res_code,
    output logic [PA_W-1:0]   res_paddr,
    output logic [2:0]        res_perm,
    output logic [SET_W-1:0]  res_set,
    output logic [WAY_W-1:0]  res_way
);

    logic [ADDR_W-1:0]          addr_q;
    acc_e                       kind_q;
    logic                       wide_q, isp_q, dsp_q, user_q;
    logic [NPID-1:0][PID_W-1:0] pids_q;
    logic                       alt_en_q, alt_sp_q, alt_us_q;
    logic [PID_W-1:0]           alt_pid_q;

    logic       accept;
    logic       use_alt, eff_space, eff_user;
    res_e       ev_code;
    logic [PA_W-1:0] ev_paddr;
    logic [2:0] ev_perm;
    logic       finish;
    res_e       code_q;

    assign accept = start && !busy;

    // Request capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            kind_q    <= ACC_LOAD;
            wide_q    <= 1'b0;
            isp_q     <= 1'b0;
            dsp_q     <= 1'b0;
            user_q    <= 1'b0;
            pids_q    <= '0;
            alt_en_q  <= 1'b0;
            alt_pid_q <= '0;
            alt_sp_q  <= 1'b0;
            alt_us_q  <= 1'b0;
        end else if (accept) begin
            addr_q    <= req_addr;
            kind_q    <= acc_e'(req_kind);
            wide_q    <= req_wide;
            isp_q     <= cpu_ispace;
            dsp_q     <= cpu_dspace;
            user_q    <= cpu_user;
            pids_q    <= {pid_c, pid_b, pid_a};
            alt_en_q  <= alt_en;
            alt_pid_q <= alt_pid;
            alt_sp_q  <= alt_space;
            alt_us_q  <= alt_user;
        end
    end

    tlbck_ctx i_ctx (
        .kind       (kind_q),
        .cpu_ispace (isp_q),
        .cpu_dspace (dsp_q),
        .cpu_user   (user_q),
        .alt_en     (alt_en_q),
        .alt_space  (alt_sp_q),
        .alt_user   (alt_us_q),
        .use_alt    (use_alt),
        .eff_space  (eff_space),
        .eff_user   (eff_user)
    );

    tlbck_eval #(.ADDR_W(ADDR_W), .PA_W(PA_W), .PID_W(PID_W), .SIZE_W(SIZE_W)) i_eval (
        .addr      (addr_q),
        .wide      (wide_q),
        .kind      (kind_q),
        .use_alt   (use_alt),
        .eff_space (eff_space),
        .eff_user  (eff_user),
        .pids      (pids_q),
        .alt_pid   (alt_pid_q),
        .ent_valid (ent_valid),
        .ent_size  (ent_size),
        .ent_tid   (ent_tid),
        .ent_space (ent_space),
        .ent_vpage (ent_vpage),
        .ent_ppage (ent_ppage),
        .ent_perm  (ent_perm),
        .code      (ev_code),
        .paddr     (ev_paddr),
        .perm      (ev_perm)
    );

    tlbck_seq #(.NSETS(NSETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .decided (ev_code != RES_MISS),
        .busy    (busy),
        .set_q   (cand_set),
        .way_q   (cand_way),
        .finish  (finish)
    );

    // Result registers: loaded when the walk ends, cleared fields on a full miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            code_q    <= RES_MISS;
            res_paddr <= '0;
            res_perm  <= '0;
            res_set   <= '0;
            res_way   <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                code_q <= ev_code;
                if (ev_code == RES_MISS) begin
                    res_paddr <= '0;
                    res_perm  <= '0;
                    res_set   <= '0;
                    res_way   <= '0;
                end else begin
                    res_paddr <= ev_paddr;
                    res_perm  <= ev_perm;
                    res_set   <= cand_set;
                    res_way   <= cand_way;
                end
            end
        end
    end

    assign res_code = code_q;

    // R1: the result strobe only appears once the walker is idle again.
    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: a full miss reports no address, permission or slot.
    p_miss_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_code == RES_MISS) |-> (res_paddr == '0 && res_perm == '0));

    // R9: fetches never report a data violation.
    p_fetch_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_q == ACC_FETCH) |-> (res_code != RES_DVIOL));

    // R9: loads and stores never report an execute violation.
    p_data_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_q != ACC_FETCH) |-> (res_code != RES_XVIOL));

    // R3: the minimum-page offset bits pass through on a hit.
    p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_code == RES_HIT) |->
        (res_paddr[MIN_PAGE_SHIFT-1:0] == addr_q[MIN_PAGE_SHIFT-1:0]));

endmodule

// File: tb/test_tlb_entry_checker.sv
`timescale 1ns/1ps
module test_tlb_entry_checker;

    localparam int NENT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_wide = 1'b1;
    logic        cpu_ispace = 1'b0, cpu_dspace = 1'b0, cpu_user = 1'b0;
    logic [13:0] pid_a = '0, pid_b = '0, pid_c = '0;
    logic        alt_en = 1'b0;
    logic [13:0] alt_pid = '0;
    logic        alt_space = 1'b0, alt_user = 1'b0;
    logic [0:0]  cand_set;
    logic [1:0]  cand_way;
    logic        busy, done;
    logic [1:0]  res_code;
    logic [47:0] res_paddr;
    logic [2:0]  res_perm;
    logic [0:0]  res_set;
    logic [1:0]  res_way;

    logic        m_valid [NENT];
    logic [3:0]  m_size  [NENT];
    logic [13:0] m_tid   [NENT];
    logic        m_space [NENT];
    logic [63:0] m_vpage [NENT];
    logic [47:0] m_ppage [NENT];
    logic [5:0]  m_perm  [NENT];

    wire [2:0] cidx = {cand_set, cand_way};

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    tlb_entry_checker i_tlb_entry_checker (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_addr(req_addr), .req_kind(req_kind), .req_wide(req_wide),
        .cpu_ispace(cpu_ispace), .cpu_dspace(cpu_dspace), .cpu_user(cpu_user),
        .pid_a(pid_a), .pid_b(pid_b), .pid_c(pid_c),
        .alt_en(alt_en), .alt_pid(alt_pid), .alt_space(alt_space), .alt_user(alt_user),
        .cand_set(cand_set), .cand_way(cand_way),
        .ent_valid(m_valid[cidx]), .ent_size(m_size[cidx]), .ent_tid(m_tid[cidx]),
        .ent_space(m_space[cidx]), .ent_vpage(m_vpage[cidx]), .ent_ppage(m_ppage[cidx]),
        .ent_perm(m_perm[cidx]),
        .busy(busy), .done(done), .res_code(res_code), .res_paddr(res_paddr),
        .res_perm(res_perm), .res_set(res_set), .res_way(res_way)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < NENT; i++) begin
            m_valid[i] = 1'b0; m_size[i] = '0; m_tid[i] = '0; m_space[i] = 1'b0;
            m_vpage[i] = '0; m_ppage[i] = '0; m_perm[i] = '0;
        end
        req_kind = 2'd0; req_wide = 1'b1; cpu_ispace = 1'b0; cpu_dspace = 1'b0;
        cpu_user = 1'b0; pid_a = '0; pid_b = '0; pid_c = '0;
        alt_en = 1'b0; alt_pid = '0; alt_space = 1'b0; alt_user = 1'b0;
    endtask

    task automatic put(input int i, input logic [3:0] sz, input logic [13:0] tid,
                       input logic sp, input logic [63:0] vp, input logic [47:0] pp,
                       input logic [5:0] pm);
        m_valid[i] = 1'b1; m_size[i] = sz; m_tid[i] = tid; m_space[i] = sp;
        m_vpage[i] = vp; m_ppage[i] = pp; m_perm[i] = pm;
    endtask

    // Run one walk; lat = clock edges from the accepting edge until done is seen.
    task automatic walk(output int lat);
        @(negedge clk); start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        lat = 0;
        while (lat < 40) begin
            @(posedge clk); #1;
            lat++;
            if (done) break;
        end
        @(posedge clk); #1;
        chk("R1 done single cycle", {63'b0, done}, 64'd0);
    endtask

    task automatic expect_res(input string tag, input int lat, input int exp_lat,
                              input logic [1:0] code, input logic [47:0] pa,
                              input logic [2:0] pm, input int idx);
        chk({tag, " code"}, {62'b0, res_code}, {62'b0, code});
        chk({tag, " paddr"}, {16'b0, res_paddr}, {16'b0, pa});
        chk({tag, " perm"}, {61'b0, res_perm}, {61'b0, pm});
        chk({tag, " slot"}, {61'b0, res_set, res_way}, 64'(idx));
        chk({tag, " R1 latency"}, 64'(lat), 64'(exp_lat));
    endtask

    task automatic t_reset();
        chk("R1 reset busy", {63'b0, busy}, 64'd0);
        chk("R1 reset done", {63'b0, done}, 64'd0);
        chk("R10 reset code", {62'b0, res_code}, 64'd0);
    endtask

    task automatic t_basic();
        int lat;
        clear_all();
        put(2, 4'd2, 14'd0, 1'b0, 64'h1234_5000, 48'h00AB_CDE0_0000, 6'b111_001);
        req_addr = 64'h1234_5678;
        walk(lat);
        expect_res("R3 sup load", lat, 3, 2'd1, 48'h00AB_CDE0_0678, 3'b111, 2);
        cpu_user = 1'b1;
        walk(lat);
        expect_res("R9 user load", lat, 3, 2'd1, 48'h00AB_CDE0_0678, 3'b001, 2);
    endtask

    task automatic t_size();
        int lat;
        clear_all();
        put(0, 4'd0, 14'd0, 1'b0, 64'h4000, 48'h9000, 6'b111_000);
        req_addr = 64'h43FF;
        walk(lat);
        expect_res("R2 1KiB inside", lat, 1, 2'd1, 48'h93FF, 3'b111, 0);
        req_addr = 64'h4400;
        walk(lat);
        expect_res("R2 1KiB outside", lat, 8, 2'd0, 48'h0, 3'b000, 0);
    endtask

    task automatic t_narrow();
        int lat;
        clear_all();
        put(0, 4'd0, 14'd0, 1'b0, 64'h8000, 48'h7_0000, 6'b111_000);
        req_addr = 64'hFFFF_0000_0000_8010;
        req_wide = 1'b0;
        walk(lat);
        expect_res("R4 narrow drops upper", lat, 1, 2'd1, 48'h7_0010, 3'b111, 0);
        req_wide = 1'b1;
        walk(lat);
        expect_res("R4 wide compares upper", lat, 8, 2'd0, 48'h0, 3'b000, 0);
    endtask

    task automatic t_pid();
        int lat;
        clear_all();
        put(1, 4'd2, 14'd5, 1'b0, 64'h1234_5000, 48'h5000, 6'b011_000);
        req_addr = 64'h1234_5004;
        pid_a = 14'd3; pid_b = 14'd5; pid_c = 14'd0;
        walk(lat);
        expect_res("R5 second pid", lat, 2, 2'd1, 48'h5004, 3'b011, 1);
        pid_b = 14'd0; pid_c = 14'd5;
        walk(lat);
        expect_res("R5 third pid", lat, 2, 2'd1, 48'h5004, 3'b011, 1);
        pid_b = 14'd4; pid_c = 14'd6;
        walk(lat);
        expect_res("R5 no pid", lat, 8, 2'd0, 48'h0, 3'b000, 0);
        pid_a = 14'd5;
        walk(lat);
        expect_res("R5 first pid", lat, 2, 2'd1, 48'h5004, 3'b011, 1);
    endtask

    task automatic t_alt();
        int lat;
        clear_all();
        put(3, 4'd2, 14'd7, 1'b1, 64'h1234_5000, 48'h6000, 6'b010_000);
        req_addr = 64'h1234_5010; req_kind = 2'd1;
        alt_en = 1'b1; alt_pid = 14'd7; alt_space = 1'b1; alt_user = 1'b0;
        pid_a = 14'd1; cpu_dspace = 1'b0; cpu_user = 1'b1;
        walk(lat);
        expect_res("R6 alt store", lat, 4, 2'd1, 48'h6010, 3'b010, 3);
        alt_pid = 14'd8; pid_a = 14'd7;
        walk(lat);
        expect_res("R6 machine pid ignored", lat, 8, 2'd0, 48'h0, 3'b000, 0);
        alt_pid = 14'd7; alt_space = 1'b0;
        walk(lat);
        expect_res("R6 alt space", lat, 8, 2'd0, 48'h0, 3'b000, 0);
    endtask

    task automatic t_fetch();
        int lat;
        clear_all();
        put(4, 4'd2, 14'd0, 1'b1, 64'h1234_5000, 48'hA000, 6'b000_101);
        req_addr = 64'h1234_5020; req_kind = 2'd2;
        cpu_ispace = 1'b1; cpu_dspace = 1'b0; cpu_user = 1'b1;
        alt_en = 1'b1; alt_pid = 14'd9; alt_space = 1'b0; alt_user = 1'b0;
        walk(lat);
        expect_res("R7 fetch user", lat, 5, 2'd1, 48'hA020, 3'b101, 4);
        cpu_user = 1'b0;
        walk(lat);
        expect_res("R9 fetch denied", lat, 5, 2'd3, 48'hA020, 3'b000, 4);
    endtask

    task automatic t_space();
        int lat;
        clear_all();
        put(0, 4'd2, 14'd0, 1'b1, 64'h1234_5000, 48'hB000, 6'b111_000);
        put(5, 4'd2, 14'd0, 1'b0, 64'h1234_5000, 48'hC000, 6'b111_000);
        req_addr = 64'h1234_5040;
        walk(lat);
        expect_res("R8 space mismatch skipped", lat, 6, 2'd1, 48'hC040, 3'b111, 5);
    endtask

    task automatic t_violation_stops();
        int lat;
        clear_all();
        put(1, 4'd2, 14'd0, 1'b0, 64'h1234_5000, 48'hD000, 6'b001_000);
        put(3, 4'd2, 14'd0, 1'b0, 64'h1234_5000, 48'hE000, 6'b011_000);
        req_addr = 64'h1234_5008; req_kind = 2'd1;
        walk(lat);
        expect_res("R10 first match denies", lat, 2, 2'd2, 48'hD008, 3'b001, 1);
    endtask

    task automatic t_invalid();
        int lat;
        clear_all();
        put(0, 4'd2, 14'd0, 1'b0, 64'h1234_5000, 48'hF000, 6'b111_000);
        m_valid[0] = 1'b0;
        put(6, 4'd2, 14'd0, 1'b0, 64'h1234_5000, 48'h1_1000, 6'b111_000);
        req_addr = 64'h1234_5100;
        walk(lat);
        expect_res("R11 invalid skipped", lat, 7, 2'd1, 48'h1_1100, 3'b111, 6);
    endtask

    task automatic t_busy_start();
        int lat;
        clear_all();
        put(5, 4'd2, 14'd0, 1'b0, 64'h1234_5000, 48'h2_0000, 6'b111_000);
        req_addr = 64'h1234_5ABC;
        @(negedge clk); start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk); start = 1'b1; req_addr = 64'h9999_9000;
        @(posedge clk); #1 start = 1'b0;
        lat = 1;
        while (lat < 40) begin
            @(posedge clk); #1;
            lat++;
            if (done) break;
        end
        @(posedge clk); #1;
        chk("R1 no restart after walk", {63'b0, busy}, 64'd0);
        expect_res("R1 start while busy", lat, 6, 2'd1, 48'h2_0ABC, 3'b111, 5);
    endtask

    task automatic t_all_miss();
        int lat;
        clear_all();
        req_addr = 64'h1234_5000;
        walk(lat);
        expect_res("R10 all miss", lat, 8, 2'd0, 48'h0, 3'b000, 0);
    endtask

    initial begin
        #1_000_000;
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        clear_all();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_size();
        t_narrow();
        t_pid();
        t_alt();
        t_fetch();
        t_space();
        t_violation_stops();
        t_invalid();
        t_busy_start();
        t_all_miss();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule